// File: doc/BRIEF.md
# Serial Flash Status Register and Write-Enable Latch

This block holds the volatile status byte of a serial NOR flash command decoder. The decoder hands it one-cycle command strobes: enable writes, disable writes, write the status byte, and a start strobe and a completion strobe for each of the four program and erase kinds (page program, sector erase, block erase, chip erase). The array sequencer adds a level signal that stays high while it is doing internal work. From these inputs the block keeps a write-enable latch, three block-protect bits and a lock bit. It also tracks which program or erase operation is running.

It drives two outputs. The first is the status byte, which the serial front end shifts out for a read-status command. The second is a grant, which the decoder uses to pass or drop program and erase commands. After power-up the protect bits cover the whole array. The write-enable latch clears itself whenever a program, an erase or a status write finishes, so every modifying operation needs a fresh enable. When the lock bit is set, the protect bits cannot be changed.

Top module: `flash_status_reg`

## Requirements
- R1: While reset is asserted and right after it, the status byte is 0x1C (protect bits all 1, every other bit 0) and `op_grant` is 0.
- R2: Status byte layout: bit 0 busy, bit 1 write-enable latch, bits 4:2 protect bits (bit 2 the least significant), bits 6:5 always read 0, bit 7 lock. Data bits 6:5, 1 and 0 of a status write have no effect.
- R3: A write-enable strobe sets the latch on the next clock only when busy is 0. While busy is 1 it is ignored.
- R4: The latch clears on the next clock after a write-disable strobe taken while busy is 0, and after an accepted status write.
- R5: Any completion strobe (`op_done` nonzero) clears the latch on the next clock, whether or not busy is 1.
- R6: `op_grant` equals latch AND NOT busy. A start strobe given while the grant is 1 makes busy read 1 from the next clock. A start strobe given while the grant is 0 changes nothing.
- R7: Busy reads 1 while `seq_busy` is 1, and while an accepted operation has not yet seen the completion strobe at its own bit index of `op_done`.
- R8: A status write given while busy is 0 is accepted. It loads data bit 7 into the lock bit and, when the lock was 0 before the write, loads data bits 4:2 into the protect bits.
- R9: When the lock bit is 1, an accepted status write leaves the protect bits unchanged but still writes the lock bit from data bit 7.
- R10: While busy is 1, status-write and write-disable strobes are ignored: the lock, protect bits and latch keep their values.
- R11: Simultaneous strobes: a clearing event wins over write-enable. When several start bits are high, only the lowest index is recorded as running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_wr_en | input | 1 | Write-enable command strobe |
| cmd_wr_dis | input | 1 | Write-disable command strobe |
| cmd_sr_write | input | 1 | Status-write command strobe |
| sr_wdata | input | 8 | Data byte for a status write |
| op_start | input | 4 | Start strobes, index 0 page program, 1 sector erase, 2 block erase, 3 chip erase |
| op_done | input | 4 | Completion strobes, same indexing as `op_start` |
| seq_busy | input | 1 | Array sequencer internal busy level |
| status_byte | output | 8 | Status byte for a read-status command |
| op_grant | output | 1 | High when a program or erase start would be accepted |

## Verification
The hardest situations to reach are the ones where several effects meet: a completion strobe that clears the latch while a different operation stays in flight, a status write that arrives while the lock is set, and write-disable or status-write strobes that arrive during busy. A directed sequence sets up each of these on purpose. Examples include starting two operation kinds at once and then completing only the one that was not recorded, or setting the lock and then writing a different protect value. After that, a long random phase with sparse strobes and completion strobes biased toward running operations is compared against a behavioural model on every clock.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

  localparam int SR_W    = 8;
  localparam int PROT_W  = 3;
  localparam int OP_KNDS = 4;

  localparam logic [PROT_W-1:0] PROT_RESET = '1;

  typedef struct packed {
    logic              lock;
    logic [1:0]        rsvd;
    logic [PROT_W-1:0] prot;
    logic              wel;
    logic              busy;
  } status_t;

endpackage

// File: rtl/sr_run_tracker.sv
module sr_run_tracker #(
  parameter int NUM_OPS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OPS-1:0] op_start_i,
  input  logic [NUM_OPS-1:0] op_done_i,
  input  logic               grant_i,
  input  logic               seq_busy_i,
  output logic               busy_o
);

  logic [NUM_OPS-1:0] run_q, run_d, run_en, pick;
  logic               accept;

  assign accept = (|op_start_i) & grant_i;

  // lowest index start wins
  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (op_start_i[i] && (pick == '0)) pick[i] = 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_run
    logic set_g, clr_g;
    assign set_g = accept & pick[g];
    assign clr_g = op_done_i[g];
    always_comb begin
      run_en[g] = set_g | clr_g;
      run_d[g]  = set_g;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      for (int i = 0; i < NUM_OPS; i++) begin
        if (run_en[i]) run_q[i] <= run_d[i];
      end
    end
  end

  assign busy_o = (|run_q) | seq_busy_i;

  AST_RUN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(run_q)); // R11

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o); // R6

endmodule

// File: rtl/sr_wel_latch.sv
module sr_wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wren_i,
  input  logic wrdi_i,
  input  logic wrsr_ok_i,
  input  logic any_done_i,
  input  logic busy_i,
  output logic wel_o
);

  logic wel_q, wel_d, wel_en;
  logic clr, set;

  always_comb begin
    clr    = any_done_i | (wrdi_i & ~busy_i) | wrsr_ok_i;
    set    = wren_i & ~busy_i;
    wel_en = clr | set;
    wel_d  = ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wel_q <= 1'b0;
    else if (wel_en) wel_q <= wel_d;
  end

  assign wel_o = wel_q;

  AST_WEL_RISE_NEEDS_WREN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(wren_i && !busy_i)); // R3

  AST_WEL_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    any_done_i |=> !wel_q); // R5

  AST_WEL_BUSY_WRDI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && wrdi_i && !any_done_i) |=> $stable(wel_q)); // R10

endmodule

// File: rtl/sr_protect.sv
module sr_protect
  import flash_sr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrsr_ok_i,
  input  logic [SR_W-1:0]   wdata_i,
  output logic [PROT_W-1:0] prot_o,
  output logic              lock_o
);

  status_t            wfield;
  logic [PROT_W-1:0]  prot_q, prot_d;
  logic               lock_q, lock_d;
  logic               prot_en, lock_en;

  assign wfield = status_t'(wdata_i);

  always_comb begin
    lock_en = wrsr_ok_i;
    lock_d  = wfield.lock;
    prot_en = wrsr_ok_i & ~lock_q;
    prot_d  = wfield.prot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= PROT_RESET;
      lock_q <= 1'b0;
    end else begin
      if (prot_en) prot_q <= prot_d;
      if (lock_en) lock_q <= lock_d;
    end
  end

  assign prot_o = prot_q;
  assign lock_o = lock_q;

  AST_PROT_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(prot_q)); // R9

  AST_PROT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrsr_ok_i |=> $stable({lock_q, prot_q})); // R10

endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import flash_sr_pkg::*;
#(
  parameter int NUM_OPS = OP_KNDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr_en,
  input  logic               cmd_wr_dis,
  input  logic               cmd_sr_write,
  input  logic [SR_W-1:0]    sr_wdata,
  input  logic [NUM_OPS-1:0] op_start,
  input  logic [NUM_OPS-1:0] op_done,
  input  logic               seq_busy,
  output logic [SR_W-1:0]    status_byte,
  output logic               op_grant
);

  logic              busy, wel, lock, wrsr_ok;
  logic [PROT_W-1:0] prot;
  status_t           sr;

  assign wrsr_ok  = cmd_sr_write & ~busy;
  assign op_grant = wel & ~busy;

  sr_run_tracker #(.NUM_OPS(NUM_OPS)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_start_i (op_start),
    .op_done_i  (op_done),
    .grant_i    (op_grant),
    .seq_busy_i (seq_busy),
    .busy_o     (busy)
  );

  sr_wel_latch u_wel (
    .clk        (clk),
    .rst_n      (rst_n),
    .wren_i     (cmd_wr_en),
    .wrdi_i     (cmd_wr_dis),
    .wrsr_ok_i  (wrsr_ok),
    .any_done_i (|op_done),
    .busy_i     (busy),
    .wel_o      (wel)
  );

  sr_protect u_prot (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrsr_ok_i (wrsr_ok),
    .wdata_i   (sr_wdata),
    .prot_o    (prot),
    .lock_o    (lock)
  );

  always_comb begin
    sr.lock = lock;
    sr.rsvd = '0;
    sr.prot = prot;
    sr.wel  = wel;
    sr.busy = busy;
  end

  assign status_byte = sr;

endmodule

// File: tb/test_flash_status_reg.sv
module test_flash_status_reg;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_wr_en, cmd_wr_dis, cmd_sr_write, seq_busy;
  logic [7:0] sr_wdata;
  logic [3:0] op_start, op_done;
  logic [7:0] status_byte;
  logic       op_grant;

  int n_vec  = 0;
  int n_fail = 0;
  bit finished = 0;

  // behavioural model state
  int m_wel, m_lock, m_prot, m_run;

  always #2 clk = ~clk;

  flash_status_reg i_flash_status_reg (
    .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_dis(cmd_wr_dis),
    .cmd_sr_write(cmd_sr_write), .sr_wdata(sr_wdata), .op_start(op_start),
    .op_done(op_done), .seq_busy(seq_busy), .status_byte(status_byte),
    .op_grant(op_grant)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_busy();
    return ((m_run != 0) || seq_busy) ? 1 : 0;
  endfunction

  function automatic int m_status();
    return (m_lock << 7) | (m_prot << 2) | (m_wel << 1) | m_busy();
  endfunction

  // model: next state at every clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wel = 0; m_lock = 0; m_prot = 7; m_run = 0;
    end else begin
      int b, g, nrun;
      b = m_busy();
      g = m_wel && !b;
      nrun = m_run & ~int'(op_done);
      if (op_start != 0 && g) begin
        for (int i = 0; i < 4; i++) begin
          if (op_start[i]) begin nrun = nrun | (1 << i); break; end
        end
      end
      if (op_done != 0 || (cmd_wr_dis && !b) || (cmd_sr_write && !b)) m_wel = 0;
      else if (cmd_wr_en && !b) m_wel = 1;
      if (cmd_sr_write && !b) begin
        if (!m_lock) m_prot = int'(sr_wdata[4:2]);
        m_lock = int'(sr_wdata[7]);
      end
      m_run = nrun;
    end
  end

  // compare on every clock, away from the edges
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk("R7 busy bit",      int'(status_byte[0]),   m_busy());
      chk("R3 latch bit",     int'(status_byte[1]),   m_wel);
      chk("R8 protect bits",  int'(status_byte[4:2]), m_prot);
      chk("R2 reserved bits", int'(status_byte[6:5]), 0);
      chk("R8 lock bit",      int'(status_byte[7]),   m_lock);
      chk("R6 grant",         int'(op_grant),         (m_wel && !m_busy()) ? 1 : 0);
    end
  end

  task automatic idle();
    cmd_wr_en = 0; cmd_wr_dis = 0; cmd_sr_write = 0;
    sr_wdata = '0; op_start = '0; op_done = '0;
  endtask

  task automatic pulse(input logic en, input logic dis, input logic wr,
                       input logic [7:0] d, input logic [3:0] st, input logic [3:0] dn);
    @(negedge clk);
    cmd_wr_en = en; cmd_wr_dis = dis; cmd_sr_write = wr;
    sr_wdata = d; op_start = st; op_done = dn;
    @(negedge clk);
    idle();
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; seq_busy = 0; idle();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset status", int'(status_byte), 8'h1C);
    chk("R1 reset grant",  int'(op_grant), 0);
    @(negedge clk); rst_n = 1; #1;
    chk("R1 status after release", int'(status_byte), 8'h1C);

    pulse(1,0,0,8'h00,4'h0,4'h0); chk("R3 enable sets latch", int'(status_byte), 8'h1E);
    chk("R6 grant with latch", int'(op_grant), 1);
    pulse(0,0,1,8'hFF,4'h0,4'h0); chk("R8 write lock+prot, R4 latch clears", int'(status_byte), 8'h9C);
    pulse(1,0,0,8'h00,4'h0,4'h0); chk("R3 enable again", int'(status_byte), 8'h9E);
    pulse(0,0,1,8'h00,4'h0,4'h0); chk("R9 locked prot kept, lock cleared", int'(status_byte), 8'h1C);
    pulse(0,0,1,8'h63,4'h0,4'h0); chk("R2 ignored data bits", int'(status_byte), 8'h00);
    pulse(1,0,0,8'h00,4'h0,4'h0); pulse(0,1,0,8'h00,4'h0,4'h0);
    chk("R4 disable clears latch", int'(status_byte), 8'h00);
    pulse(0,0,0,8'h00,4'h1,4'h0); chk("R6 start without latch rejected", int'(status_byte), 8'h00);

    pulse(1,0,0,8'h00,4'h0,4'h0); pulse(0,0,0,8'h00,4'h4,4'h0);
    chk("R6 accepted start sets busy", int'(status_byte), 8'h03);
    chk("R6 grant low while busy", int'(op_grant), 0);
    pulse(0,0,1,8'h9C,4'h0,4'h0); chk("R10 status write while busy ignored", int'(status_byte), 8'h03);
    pulse(0,1,0,8'h00,4'h0,4'h0); chk("R10 disable while busy ignored", int'(status_byte), 8'h03);
    pulse(0,0,0,8'h00,4'h0,4'h4); chk("R5 completion clears latch and busy", int'(status_byte), 8'h00);

    pulse(1,0,0,8'h00,4'h0,4'h0); pulse(0,0,0,8'h00,4'h6,4'h0);
    chk("R11 two starts", int'(status_byte), 8'h03);
    pulse(0,0,0,8'h00,4'h0,4'h4); chk("R11 only lowest start recorded, R5 latch cleared", int'(status_byte), 8'h01);
    pulse(0,0,0,8'h00,4'h0,4'h2); chk("R7 own completion ends busy", int'(status_byte), 8'h00);

    @(negedge clk); seq_busy = 1; #1;
    chk("R7 sequencer busy shown", int'(status_byte), 8'h01);
    pulse(1,0,0,8'h00,4'h0,4'h0); chk("R3 enable ignored while busy", int'(status_byte), 8'h01);
    @(negedge clk); seq_busy = 0; #1;
    chk("R7 sequencer busy gone", int'(status_byte), 8'h00);

    pulse(1,1,0,8'h00,4'h0,4'h0); chk("R11 disable beats enable", int'(status_byte), 8'h00);
    pulse(1,0,0,8'h00,4'h0,4'h0);
    pulse(1,0,1,8'h04,4'h0,4'h0); chk("R11 status write beats enable", int'(status_byte), 8'h04);

    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      cmd_wr_en    = ($urandom % 5) == 0;
      cmd_wr_dis   = ($urandom % 23) == 0;
      cmd_sr_write = ($urandom % 9) == 0;
      sr_wdata     = 8'($urandom);
      op_start     = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      if (m_run != 0 && ($urandom % 6) == 0)
        op_done = (($urandom % 3) == 0) ? 4'($urandom) : 4'(m_run);
      else
        op_done = (($urandom % 40) == 0) ? 4'($urandom) : 4'h0;
      seq_busy = ($urandom % 14) == 0;
    end
    @(negedge clk); idle(); seq_busy = 0;
    repeat (2) @(negedge clk);
    #2;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule